// File: doc/BRIEF.md
# IO Pad Function Multiplexer

This block routes every IO pad of a chip to one of several peripheral functions. Each pad has its own select field. The value of that field picks which function owns the pad. The pad itself exposes three signals: a drive value and a drive enable, both going toward the pad, and a sampled value coming back from it. Peripheral functions come in three kinds:

- **Output-only** functions only drive a value.
- **Input-only** functions only listen.
- **Bidirectional** functions, such as general-purpose lines, supply a value plus their own drive enable and also receive the pad value.

A select therefore moves the data and the direction control together.

The routing is purely combinational. The select values come from an external configuration register through plain input ports. A pad whose select names no function is left undriven and feeds nothing. Every function input that no pad currently serves reads as zero. A function input that several pads select at once receives the OR of those pads.

The default function map is fixed in the package. It serves four pads, two output-only functions, two input-only functions and four bidirectional lines. Each pad offers between two and four functions, so the pads have different select widths.

Top module: `pinmux_fabric`

## Requirements
- R1: A pad routed to an output-only function drives that function's value on `pad_o` and holds `pad_oe` at 1.
- R2: A pad routed to an input-only function drives `pad_o` and `pad_oe` to 0, and its `pad_i` reaches that function's `in_fn_q` bit.
- R3: A pad routed to a bidirectional function takes both `pad_o` and `pad_oe` from that function's `bid_fn_d` and `bid_fn_oe` bits, and its `pad_i` reaches that function's `bid_fn_q` bit.
- R4: A select value beyond the functions listed for a pad drives that pad's `pad_o` and `pad_oe` to 0, and its `pad_i` reaches no function.
- R5: Every `in_fn_q` and `bid_fn_q` bit that no pad currently selects is 0.
- R6: A function input selected by several pads at once equals the OR of those pads' `pad_i` values.
- R7: `pad_sel` packs the per-pad fields from bit 0 upward: pad0 in [1:0], pad1 in [3:2], pad2 in [4], pad3 in [6:5]. The function map per pad, listed as select value and function:
  - pad0: 0 bid0, 1 out0, 2 in0, 3 none.
  - pad1: 0 bid1, 1 in0, 2 out1, 3 in1.
  - pad2: 0 bid2, 1 in1.
  - pad3: 0 bid3, 1 out0, 2 bid0, 3 none.
- R8: Every output follows its inputs with no clock. A change of data or select is visible before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pad_sel | input | 7 | Packed per-pad function select fields |
| pad_i | input | 4 | Value sampled from each pad |
| out_fn_d | input | 2 | Values of the output-only functions |
| bid_fn_d | input | 4 | Drive values of the bidirectional functions |
| bid_fn_oe | input | 4 | Drive enables of the bidirectional functions |
| pad_o | output | 4 | Drive value toward each pad |
| pad_oe | output | 4 | Drive enable toward each pad |
| in_fn_q | output | 2 | Values delivered to the input-only functions |
| bid_fn_q | output | 4 | Values delivered to the bidirectional functions |

## Verification
Two things can happen in the same evaluation. A pad can drive as one function's owner while a second pad feeds the input side of a function that is also selected elsewhere. The clearest case is bid0, which can be selected on pad0 and pad3 at once: both pads drive its value and enable, and its input merges the two pads. The vectors provoke this, together with in0 shared by pad0 and pad1. Each vector raises one pad input at a time, so the merged result is judged against the OR computed per pad. An out-of-range pad is held high alongside, to show that it contributes nothing.

// File: rtl/pm_fabric_pkg.sv
package pm_fabric_pkg;

    localparam int PM_PADS   = 4;
    localparam int PM_MAX_FN = 4;
    localparam int PM_OUT_FN = 2;
    localparam int PM_IN_FN  = 2;
    localparam int PM_BID_FN = 4;
    localparam int PM_IDX_W  = 3;

    typedef enum logic [1:0] {
        FN_NONE = 2'd0,
        FN_OUT  = 2'd1,
        FN_IN   = 2'd2,
        FN_BID  = 2'd3
    } fn_kind_e;

    typedef struct packed {
        fn_kind_e              kind;
        logic [PM_IDX_W-1:0]   idx;
    } fn_route_t;

    function automatic fn_route_t mk_route(input fn_kind_e k, input int i);
        fn_route_t r;
        r.kind = k;
        r.idx  = i[PM_IDX_W-1:0];
        return r;
    endfunction

    // Function map: (pad, select) -> function kind and index
    function automatic fn_route_t route_of(input int pad, input int sel);
        fn_route_t r;
        r = mk_route(FN_NONE, 0);
        case (pad)
            0: case (sel)
                   0: r = mk_route(FN_BID, 0);
                   1: r = mk_route(FN_OUT, 0);
                   2: r = mk_route(FN_IN,  0);
                   default: r = mk_route(FN_NONE, 0);
               endcase
            1: case (sel)
                   0: r = mk_route(FN_BID, 1);
                   1: r = mk_route(FN_IN,  0);
                   2: r = mk_route(FN_OUT, 1);
                   3: r = mk_route(FN_IN,  1);
                   default: r = mk_route(FN_NONE, 0);
               endcase
            2: case (sel)
                   0: r = mk_route(FN_BID, 2);
                   1: r = mk_route(FN_IN,  1);
                   default: r = mk_route(FN_NONE, 0);
               endcase
            3: case (sel)
                   0: r = mk_route(FN_BID, 3);
                   1: r = mk_route(FN_OUT, 0);
                   2: r = mk_route(FN_BID, 0);
                   default: r = mk_route(FN_NONE, 0);
               endcase
            default: r = mk_route(FN_NONE, 0);
        endcase
        return r;
    endfunction

    function automatic int fn_count(input int pad);
        int n;
        n = 0;
        for (int s = 0; s < PM_MAX_FN; s++)
            if (route_of(pad, s).kind != FN_NONE) n = s + 1;
        return n;
    endfunction

    function automatic int sel_w(input int pad);
        int n;
        n = fn_count(pad);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    function automatic int sel_ofs(input int pad);
        int o;
        o = 0;
        for (int q = 0; q < pad; q++) o += sel_w(q);
        return o;
    endfunction

endpackage

// File: rtl/pm_pad_lane.sv
module pm_pad_lane
    import pm_fabric_pkg::*;
#(
    parameter int PAD_IDX = 0,
    parameter int SEL_W   = 2,
    parameter int N_OUT   = PM_OUT_FN,
    parameter int N_IN    = PM_IN_FN,
    parameter int N_BID   = PM_BID_FN
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [N_OUT-1:0] out_fn_d,
    input  logic [N_BID-1:0] bid_fn_d,
    input  logic [N_BID-1:0] bid_fn_oe,
    output logic             pad_o,
    output logic             pad_oe,
    output logic [N_IN-1:0]  hit_in,
    output logic [N_BID-1:0] hit_bid
);

    fn_route_t ent;

    always_comb begin
        ent     = route_of(PAD_IDX, int'(sel));
        pad_o   = 1'b0;
        pad_oe  = 1'b0;
        hit_in  = '0;
        hit_bid = '0;
        case (ent.kind)
            FN_OUT: begin
                pad_oe = 1'b1;
                for (int k = 0; k < N_OUT; k++)
                    if (int'(ent.idx) == k) pad_o = out_fn_d[k];
            end
            FN_IN: begin
                for (int k = 0; k < N_IN; k++)
                    if (int'(ent.idx) == k) hit_in[k] = 1'b1;
            end
            FN_BID: begin
                for (int k = 0; k < N_BID; k++)
                    if (int'(ent.idx) == k) begin
                        pad_o      = bid_fn_d[k];
                        pad_oe     = bid_fn_oe[k];
                        hit_bid[k] = 1'b1;
                    end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pm_in_gather.sv
module pm_in_gather #(
    parameter int N_PADS = 4,
    parameter int N_FN   = 2
) (
    input  logic [N_PADS-1:0][N_FN-1:0] hit,
    input  logic [N_PADS-1:0]           pad_i,
    output logic [N_FN-1:0]             q
);

    always_comb begin
        q = '0;
        for (int p = 0; p < N_PADS; p++)
            for (int f = 0; f < N_FN; f++)
                q[f] = q[f] | (hit[p][f] & pad_i[p]);
    end

endmodule

// File: rtl/pinmux_fabric.sv
module pinmux_fabric
    import pm_fabric_pkg::*;
#(
    parameter int NUM_PADS = PM_PADS,
    parameter int NUM_OUT  = PM_OUT_FN,
    parameter int NUM_IN   = PM_IN_FN,
    parameter int NUM_BID  = PM_BID_FN
) (
    input  logic [sel_ofs(NUM_PADS)-1:0] pad_sel,
    input  logic [NUM_PADS-1:0]          pad_i,
    input  logic [NUM_OUT-1:0]           out_fn_d,
    input  logic [NUM_BID-1:0]           bid_fn_d,
    input  logic [NUM_BID-1:0]           bid_fn_oe,
    output logic [NUM_PADS-1:0]          pad_o,
    output logic [NUM_PADS-1:0]          pad_oe,
    output logic [NUM_IN-1:0]            in_fn_q,
    output logic [NUM_BID-1:0]           bid_fn_q
);

    logic [NUM_PADS-1:0][NUM_IN-1:0]  hit_in_m;
    logic [NUM_PADS-1:0][NUM_BID-1:0] hit_bid_m;

    for (genvar g = 0; g < NUM_PADS; g++) begin : g_lane
        localparam int OFS = sel_ofs(g);
        localparam int W   = sel_w(g);

        pm_pad_lane #(
            .PAD_IDX (g),
            .SEL_W   (W),
            .N_OUT   (NUM_OUT),
            .N_IN    (NUM_IN),
            .N_BID   (NUM_BID)
        ) i_lane (
            .sel       (pad_sel[OFS +: W]),
            .out_fn_d  (out_fn_d),
            .bid_fn_d  (bid_fn_d),
            .bid_fn_oe (bid_fn_oe),
            .pad_o     (pad_o[g]),
            .pad_oe    (pad_oe[g]),
            .hit_in    (hit_in_m[g]),
            .hit_bid   (hit_bid_m[g])
        );
    end

    pm_in_gather #(.N_PADS(NUM_PADS), .N_FN(NUM_IN)) i_gather_in (
        .hit   (hit_in_m),
        .pad_i (pad_i),
        .q     (in_fn_q)
    );

    pm_in_gather #(.N_PADS(NUM_PADS), .N_FN(NUM_BID)) i_gather_bid (
        .hit   (hit_bid_m),
        .pad_i (pad_i),
        .q     (bid_fn_q)
    );

endmodule

// File: rtl/pm_route_chk.sv
module pm_route_chk
    import pm_fabric_pkg::*;
#(
    parameter int NUM_PADS = PM_PADS,
    parameter int NUM_OUT  = PM_OUT_FN,
    parameter int NUM_IN   = PM_IN_FN,
    parameter int NUM_BID  = PM_BID_FN
) (
    input logic [sel_ofs(NUM_PADS)-1:0] pad_sel,
    input logic [NUM_PADS-1:0]          pad_i,
    input logic [NUM_OUT-1:0]           out_fn_d,
    input logic [NUM_BID-1:0]           bid_fn_d,
    input logic [NUM_BID-1:0]           bid_fn_oe,
    input logic [NUM_PADS-1:0]          pad_o,
    input logic [NUM_PADS-1:0]          pad_oe,
    input logic [NUM_IN-1:0]            in_fn_q,
    input logic [NUM_BID-1:0]           bid_fn_q
);

    always_comb begin
        for (int p = 0; p < NUM_PADS; p++) begin
            fn_route_t r;
            int sv;
            sv = (int'(pad_sel) >> sel_ofs(p)) & ((1 << sel_w(p)) - 1);
            r  = route_of(p, sv);
            if (r.kind == FN_OUT)
                assert_out_drive_R1: assert (pad_oe[p] && pad_o[p] == out_fn_d[int'(r.idx)])
                    else $error("output-only pad %0d mis-driven", p);
            if (r.kind == FN_IN)
                assert_in_quiet_R2: assert (!pad_oe[p] && !pad_o[p])
                    else $error("input-only pad %0d drives", p);
            if (r.kind == FN_BID)
                assert_bid_follow_R3: assert (pad_oe[p] == bid_fn_oe[int'(r.idx)] &&
                                              pad_o[p]  == bid_fn_d[int'(r.idx)])
                    else $error("bidir pad %0d mis-driven", p);
            if (r.kind == FN_NONE)
                assert_idle_pad_R4: assert (!pad_oe[p] && !pad_o[p])
                    else $error("unmapped pad %0d drives", p);
        end

        for (int f = 0; f < NUM_IN; f++) begin
            logic src;
            src = 1'b0;
            for (int p = 0; p < NUM_PADS; p++) begin
                fn_route_t r;
                int sv;
                sv = (int'(pad_sel) >> sel_ofs(p)) & ((1 << sel_w(p)) - 1);
                r  = route_of(p, sv);
                if (r.kind == FN_IN && int'(r.idx) == f && pad_i[p]) src = 1'b1;
            end
            if (in_fn_q[f])
                assert_in_sourced_R5: assert (src)
                    else $error("input function %0d high without a source", f);
        end

        for (int f = 0; f < NUM_BID; f++) begin
            logic src;
            src = 1'b0;
            for (int p = 0; p < NUM_PADS; p++) begin
                fn_route_t r;
                int sv;
                sv = (int'(pad_sel) >> sel_ofs(p)) & ((1 << sel_w(p)) - 1);
                r  = route_of(p, sv);
                if (r.kind == FN_BID && int'(r.idx) == f && pad_i[p]) src = 1'b1;
            end
            if (src)
                assert_bid_merge_R6: assert (bid_fn_q[f])
                    else $error("bidir function %0d misses a high pad", f);
        end
    end

endmodule

bind pinmux_fabric pm_route_chk #(
    .NUM_PADS (NUM_PADS),
    .NUM_OUT  (NUM_OUT),
    .NUM_IN   (NUM_IN),
    .NUM_BID  (NUM_BID)
) i_route_chk (
    .pad_sel   (pad_sel),
    .pad_i     (pad_i),
    .out_fn_d  (out_fn_d),
    .bid_fn_d  (bid_fn_d),
    .bid_fn_oe (bid_fn_oe),
    .pad_o     (pad_o),
    .pad_oe    (pad_oe),
    .in_fn_q   (in_fn_q),
    .bid_fn_q  (bid_fn_q)
);

// File: tb/test_pinmux_fabric.sv
`timescale 1ns/1ps
module test_pinmux_fabric;

    typedef struct packed {
        logic [6:0] sel;
        logic [3:0] pi;
        logic [1:0] od;
        logic [3:0] bd;
        logic [3:0] be;
        logic [3:0] po;
        logic [3:0] poe;
        logic [1:0] iq;
        logic [3:0] bq;
    } vec_t;

    localparam int NV = 8;
    // sel = {pad3[1:0], pad2, pad1[1:0], pad0[1:0]}
    localparam vec_t VECS [NV] = '{
        '{7'b00_0_00_00, 4'b1010, 2'b11, 4'b0110, 4'b1100, 4'b0110, 4'b1100, 2'b00, 4'b1010},
        '{7'b01_1_10_01, 4'b1111, 2'b10, 4'b1111, 4'b1111, 4'b0010, 4'b1011, 2'b10, 4'b0000},
        '{7'b11_1_01_10, 4'b0001, 2'b11, 4'b1111, 4'b1111, 4'b0000, 4'b0000, 2'b01, 4'b0000},
        '{7'b11_1_01_10, 4'b0010, 2'b11, 4'b1111, 4'b1111, 4'b0000, 4'b0000, 2'b01, 4'b0000},
        '{7'b11_1_01_10, 4'b1000, 2'b11, 4'b1111, 4'b1111, 4'b0000, 4'b0000, 2'b00, 4'b0000},
        '{7'b11_1_01_10, 4'b0100, 2'b11, 4'b1111, 4'b1111, 4'b0000, 4'b0000, 2'b10, 4'b0000},
        '{7'b10_0_11_00, 4'b1000, 2'b00, 4'b0001, 4'b0001, 4'b1001, 4'b1001, 2'b00, 4'b0001},
        '{7'b11_0_10_11, 4'b1111, 2'b01, 4'b1111, 4'b0000, 4'b0100, 4'b0010, 2'b00, 4'b0100}
    };

    function automatic string tag_of(input int i);
        case (i)
            0: return "R3 gpio on every pad";
            1: return "R1 R2 R5 R7 outputs";
            2: return "R6 in0 OR from pad0";
            3: return "R6 in0 OR from pad1";
            4: return "R4 unmapped pad3 feeds nothing";
            5: return "R2 in1 from pad2";
            6: return "R6 R3 bid0 on two pads";
            default: return "R1 R4 out1 low still enabled";
        endcase
    endfunction

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [6:0] pad_sel;
    logic [3:0] pad_i, bid_fn_d, bid_fn_oe, pad_o, pad_oe, bid_fn_q;
    logic [1:0] out_fn_d, in_fn_q;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    pinmux_fabric i_pinmux_fabric (
        .pad_sel   (pad_sel),
        .pad_i     (pad_i),
        .out_fn_d  (out_fn_d),
        .bid_fn_d  (bid_fn_d),
        .bid_fn_oe (bid_fn_oe),
        .pad_o     (pad_o),
        .pad_oe    (pad_oe),
        .in_fn_q   (in_fn_q),
        .bid_fn_q  (bid_fn_q)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        pad_sel   = v.sel;
        pad_i     = v.pi;
        out_fn_d  = v.od;
        bid_fn_d  = v.bd;
        bid_fn_oe = v.be;
    endtask

    initial begin
        pad_sel = '0; pad_i = '0; out_fn_d = '0; bid_fn_d = '0; bid_fn_oe = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // all-zero stimulus: every output quiet (R5, R3)
        chk("R5 reset state", "pad_o",    {4'b0, pad_o},    8'h00);
        chk("R5 reset state", "pad_oe",   {4'b0, pad_oe},   8'h00);
        chk("R5 reset state", "in_fn_q",  {6'b0, in_fn_q},  8'h00);
        chk("R5 reset state", "bid_fn_q", {4'b0, bid_fn_q}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VECS[i]);
            #1;
            chk(tag_of(i), "pad_o",    {4'b0, pad_o},    {4'b0, VECS[i].po});
            chk(tag_of(i), "pad_oe",   {4'b0, pad_oe},   {4'b0, VECS[i].poe});
            chk(tag_of(i), "in_fn_q",  {6'b0, in_fn_q},  {6'b0, VECS[i].iq});
            chk(tag_of(i), "bid_fn_q", {4'b0, bid_fn_q}, {4'b0, VECS[i].bq});
        end

        // R8: no clock edge between stimulus change and sample
        @(posedge clk); #0.5;
        apply(VECS[1]);
        #0.5;
        out_fn_d = 2'b01;
        #0.5;
        chk("R8 same-cycle data", "pad_o", {4'b0, pad_o}, 8'h09);
        pad_sel = 7'b01_1_10_11;
        #0.5;
        // R4: pad0 moved to an unused select while the clock is still high
        chk("R8 R4 same-cycle select", "pad_o",  {4'b0, pad_o},  8'h08);
        chk("R8 R4 same-cycle select", "pad_oe", {4'b0, pad_oe}, 8'h0A);

        // R7: pad2 field is bit 4 alone; flipping it moves pad2 to in1
        @(negedge clk);
        pad_sel = 7'b00_0_00_00; pad_i = 4'b0100; bid_fn_d = 4'b0100; bid_fn_oe = 4'b0100;
        #1;
        chk("R7 pad2 field gpio", "pad_oe", {4'b0, pad_oe}, 8'h04);
        pad_sel = 7'b00_1_00_00;
        #1;
        chk("R7 pad2 field in1", "in_fn_q", {6'b0, in_fn_q}, 8'h02);
        chk("R7 R5 bid2 released", "bid_fn_q", {4'b0, bid_fn_q}, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule